// File: doc/BRIEF.md
# T1 Framing-Bit Reframe Monitor

This block sits behind a T1 frame synchronizer and watches each received framing bit once frame alignment has been reached. It decides whether the bit is one that should be monitored, given the line mode (D4 12-frame superframe or ESF 24-frame superframe), the frame index and two option enables. It then compares the bit against its expected value. Every monitored mismatch produces a one-cycle increment pulse for an external error counter. The mismatch also enters a short history of error flags. When the second error lands inside a window of the last 4, 5 or 6 monitored bits, the block raises a one-cycle reframe request. A window code can switch this automatic reframe off. A manual reframe control can force a request on its rising level.

After any reframe request the monitor goes quiet and clears its history. It resumes only after the synchronizer's in-sync indication has been seen low and then high again. The same idle state follows reset.

Top module: `t1_reframe_mon`

## Requirements
- R1: In D4 mode (esf_mode=0) the odd frames 1,3,5,7,9,11 carry Ft bits with expected values 1,0,1,0,1,0. Each one is always monitored. A monitored bit whose value differs from its expected value gives ferr_inc=1 for exactly the cycle after its strobe.
- R2: In D4 mode the even frames 2,4,6,8,10,12 carry Fs bits with expected values 0,0,1,1,1,0. They are monitored only when fs_incl=1. With fs_incl=0 an errored Fs bit gives no ferr_inc.
- R3: The Fs bit of frame 12 is monitored only when fs_incl=1 and sec_yel_en=0. With sec_yel_en=1 an errored frame-12 bit gives no ferr_inc.
- R4: In ESF mode (esf_mode=1) only frames 4,8,12,16,20,24 are monitored, with expected values 0,0,1,0,1,1. Strobes at other frame indices are ignored, and fs_incl has no effect.
- R5: With crit_sel=00, an errored monitored bit that is the second error among the last 4 monitored bits (itself included) gives reframe_req=1 in the cycle after its strobe. Two errors 5 monitored bits apart give none.
- R6: crit_sel=01 uses a window of 5 monitored bits, and crit_sel=10 uses a window of 6. Errors one bit beyond the window give no reframe.
- R7: With crit_sel=11 no reframe comes from errors, while ferr_inc still pulses for each error.
- R8: A manual reframe is taken when man_reframe is 1 and was 0 in the previous cycle, outside reset. It gives reframe_req=1 in the next cycle. Holding man_reframe at 1 gives no further request, and a level held through reset is not taken.
- R9: reframe_req lasts one cycle. After a request, no ferr_inc and no automatic request occur until in_sync has been 0 and then 1. The error history is empty on resumption.
- R10: After reset both outputs are 0. The monitor stays idle, with no ferr_inc, until in_sync is seen 0 and then 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_sync | input | 1 | Frame synchronizer reports alignment |
| fbit_stb | input | 1 | One-cycle strobe per received framing-bit slot |
| fbit_val | input | 1 | Received framing-bit value |
| frame_idx | input | IDX_W | Frame number in the superframe, 1-based |
| esf_mode | input | 1 | 1 = 24-frame ESF, 0 = 12-frame D4 |
| crit_sel | input | 2 | Reframe window: 00=4, 01=5, 10=6, 11=off |
| fs_incl | input | 1 | Monitor D4 Fs bits |
| sec_yel_en | input | 1 | Frame-12 Fs carries secondary yellow, so exclude it |
| man_reframe | input | 1 | Manual reframe control, taken on its 0-to-1 change |
| ferr_inc | output | 1 | One-cycle framing-bit error increment |
| reframe_req | output | 1 | One-cycle reframe request |

## Verification
The assertions assume that fbit_stb is a single-cycle pulse and that frame_idx and the option inputs are stable while it is high. They also assume that in_sync changes only between strobes. The bench drives every input on the falling clock edge and raises each strobe for exactly one cycle. It changes in_sync and the options only with no strobe pending, so each error or request can be tied to one known framing bit.

// File: rtl/t1rm_pkg.sv
package t1rm_pkg;
   typedef enum logic [1:0] {
      ST_HUNT = 2'd0,
      ST_ARM  = 2'd1,
      ST_MON  = 2'd2
   } mon_st_t;

   localparam logic [1:0] CRIT_W4  = 2'b00;
   localparam logic [1:0] CRIT_W5  = 2'b01;
   localparam logic [1:0] CRIT_W6  = 2'b10;
   localparam logic [1:0] CRIT_OFF = 2'b11;
endpackage

// File: rtl/t1rm_fbit_class.sv
module t1rm_fbit_class #(
   parameter int IDX_W = 5
) (
   input  logic             esf_mode,
   input  logic             fs_incl,
   input  logic             sec_yel_en,
   input  logic [IDX_W-1:0] frame_idx,
   input  logic             fbit_val,
   output logic             counted,
   output logic             err
);
   logic expect_v;
   logic d4_odd;
   logic d4_ok;
   logic esf_ok;

   assign d4_odd = frame_idx[0];
   assign d4_ok  = (frame_idx >= IDX_W'(1)) && (frame_idx <= IDX_W'(12));
   assign esf_ok = (frame_idx[1:0] == 2'b00) && (frame_idx >= IDX_W'(4))
                   && (frame_idx <= IDX_W'(24));

   always_comb begin
      counted  = 1'b0;
      expect_v = 1'b0;
      if (esf_mode) begin
         counted  = esf_ok;
         expect_v = (frame_idx == IDX_W'(12)) || (frame_idx == IDX_W'(20))
                    || (frame_idx == IDX_W'(24));
      end else if (d4_ok) begin
         if (d4_odd) begin
            counted  = 1'b1;
            expect_v = (frame_idx[1:0] == 2'b01);
         end else begin
            counted  = fs_incl && !((frame_idx == IDX_W'(12)) && sec_yel_en);
            expect_v = (frame_idx == IDX_W'(6)) || (frame_idx == IDX_W'(8))
                       || (frame_idx == IDX_W'(10));
         end
      end
   end

   assign err = counted && (fbit_val != expect_v);
endmodule

// File: rtl/t1rm_err_window.sv
module t1rm_err_window #(
   parameter int WIN_A   = 4,
   parameter int WIN_B   = 5,
   parameter int WIN_C   = 6,
   parameter int ERR_LIM = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       shift_en,
   input  logic       clr,
   input  logic       err_in,
   input  logic [1:0] crit_sel,
   output logic       trip
);
   import t1rm_pkg::*;

   localparam int WMAX_AB = (WIN_A > WIN_B) ? WIN_A : WIN_B;
   localparam int WMAX    = (WMAX_AB > WIN_C) ? WMAX_AB : WIN_C;
   localparam int CW      = $clog2(WMAX + 1);

   logic [WMAX-1:0] hist_q;
   logic [WMAX-1:0] hist_nx;
   logic [2:0]      len_hit;

   assign hist_nx = {hist_q[WMAX-2:0], err_in};

   for (genvar gi = 0; gi < 3; gi++) begin : g_len
      localparam int LEN = (gi == 0) ? WIN_A : ((gi == 1) ? WIN_B : WIN_C);
      logic [CW-1:0] ones;
      always_comb begin
         ones = '0;
         for (int b = 0; b < LEN; b++) ones = ones + CW'(hist_nx[b]);
      end
      assign len_hit[gi] = err_in && (ones >= CW'(ERR_LIM));
   end

   always_comb begin
      case (crit_sel)
         CRIT_W4: trip = len_hit[0];
         CRIT_W5: trip = len_hit[1];
         CRIT_W6: trip = len_hit[2];
         default: trip = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        hist_q <= '0;
      else if (clr)      hist_q <= '0;
      else if (shift_en) hist_q <= hist_nx;
   end
endmodule

// File: rtl/t1rm_man_trig.sv
module t1rm_man_trig (
   input  logic clk,
   input  logic rst_n,
   input  logic man_reframe,
   output logic fire
);
   logic low_seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) low_seen_q <= 1'b0;
      else        low_seen_q <= !man_reframe;
   end

   assign fire = low_seen_q && man_reframe;
endmodule

// File: rtl/t1_reframe_mon.sv
module t1_reframe_mon #(
   parameter int IDX_W   = 5,
   parameter int WIN_A   = 4,
   parameter int WIN_B   = 5,
   parameter int WIN_C   = 6,
   parameter int ERR_LIM = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_sync,
   input  logic             fbit_stb,
   input  logic             fbit_val,
   input  logic [IDX_W-1:0] frame_idx,
   input  logic             esf_mode,
   input  logic [1:0]       crit_sel,
   input  logic             fs_incl,
   input  logic             sec_yel_en,
   input  logic             man_reframe,
   output logic             ferr_inc,
   output logic             reframe_req
);
   import t1rm_pkg::*;

   initial begin : p_param_chk
      assert (IDX_W >= 5) else $fatal(1, "IDX_W must hold frame 24");
      assert (ERR_LIM >= 1) else $fatal(1, "ERR_LIM must be positive");
      assert (WIN_A >= ERR_LIM && WIN_B >= ERR_LIM && WIN_C >= ERR_LIM && WIN_A >= 2)
         else $fatal(1, "windows must cover the error limit");
   end

   mon_st_t st_q;
   logic    counted;
   logic    bit_err;
   logic    active;
   logic    win_trip;
   logic    man_fire;
   logic    auto_fire;
   logic    rf_nx;

   assign active = (st_q == ST_MON) && in_sync;

   t1rm_fbit_class #(.IDX_W(IDX_W)) u_class (
      .esf_mode  (esf_mode),
      .fs_incl   (fs_incl),
      .sec_yel_en(sec_yel_en),
      .frame_idx (frame_idx),
      .fbit_val  (fbit_val),
      .counted   (counted),
      .err       (bit_err)
   );

   t1rm_err_window #(
      .WIN_A(WIN_A), .WIN_B(WIN_B), .WIN_C(WIN_C), .ERR_LIM(ERR_LIM)
   ) u_win (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_en(active && fbit_stb && counted),
      .clr     (rf_nx || !active),
      .err_in  (bit_err),
      .crit_sel(crit_sel),
      .trip    (win_trip)
   );

   t1rm_man_trig u_man (
      .clk        (clk),
      .rst_n      (rst_n),
      .man_reframe(man_reframe),
      .fire       (man_fire)
   );

   assign auto_fire = active && fbit_stb && win_trip;
   assign rf_nx     = auto_fire || man_fire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_HUNT;
         ferr_inc    <= 1'b0;
         reframe_req <= 1'b0;
      end else begin
         ferr_inc    <= active && fbit_stb && bit_err;
         reframe_req <= rf_nx;
         if (rf_nx) st_q <= ST_HUNT;
         else begin
            case (st_q)
               ST_HUNT: if (!in_sync) st_q <= ST_ARM;
               ST_ARM:  if (in_sync)  st_q <= ST_MON;
               ST_MON:  if (!in_sync) st_q <= ST_ARM;
               default: st_q <= ST_HUNT;
            endcase
         end
      end
   end
endmodule

// File: rtl/t1rm_chk.sv
module t1rm_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       in_sync,
   input logic       fbit_stb,
   input logic       man_reframe,
   input logic [1:0] crit_sel,
   input logic       ferr_inc,
   input logic       reframe_req
);
   // R9
   rf_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reframe_req |=> !reframe_req);

   // R1
   ferr_after_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ferr_inc |-> $past(fbit_stb));

   // R10
   ferr_needs_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ferr_inc |-> $past(in_sync));

   // R7
   crit_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reframe_req && ($past(crit_sel) == 2'b11)) |-> $past(man_reframe));

   // R8
   man_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (man_reframe && $past(rst_n) && !$past(man_reframe)) |=> reframe_req);
endmodule

bind t1_reframe_mon t1rm_chk u_chk (.*);

// File: tb/sim_t1_reframe_mon.sv
module sim_t1_reframe_mon;
   localparam int CLK_PER = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_sync = 1'b0;
   logic       fbit_stb = 1'b0;
   logic       fbit_val = 1'b0;
   logic [4:0] frame_idx = 5'd1;
   logic       esf_mode = 1'b0;
   logic [1:0] crit_sel = 2'b11;
   logic       fs_incl = 1'b0;
   logic       sec_yel_en = 1'b0;
   logic       man_reframe = 1'b0;
   logic       ferr_inc;
   logic       reframe_req;

   int n_tests = 0;
   int n_fail  = 0;
   logic o_fe, o_rf;

   always #(CLK_PER/2) clk = ~clk;

   t1_reframe_mon u0 (.*);

   task automatic chk(input string tag, input logic act, input logic exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic d4_exp(input int f);
      if (f % 2 == 1) return (f == 1 || f == 5 || f == 9);
      return (f == 6 || f == 8 || f == 10);
   endfunction

   task automatic send(input int f, input logic v);
      frame_idx = 5'(f);
      fbit_val  = v;
      fbit_stb  = 1'b1;
      tick();
      o_fe = ferr_inc;
      o_rf = reframe_req;
      fbit_stb = 1'b0;
   endtask

   task automatic restart(input logic [1:0] crit);
      crit_sel = crit; esf_mode = 0; fs_incl = 0; sec_yel_en = 0;
      man_reframe = 0; in_sync = 0; rst_n = 0;
      tick();
      rst_n = 1;
      tick(); tick();
      in_sync = 1;
      tick(); tick();
   endtask

   task automatic t_reset();
      rst_n = 0; in_sync = 0;
      tick();
      chk("R10 ferr at reset", ferr_inc, 1'b0);
      chk("R10 rf at reset", reframe_req, 1'b0);
      rst_n = 1; in_sync = 1;
      tick();
      send(1, 1'b0);
      chk("R10 idle before sync seen low", o_fe, 1'b0);
   endtask

   task automatic t_d4_ft();
      int bad = 0;
      restart(2'b11);
      for (int f = 1; f <= 12; f++) begin
         send(f, d4_exp(f));
         if (o_fe) bad++;
      end
      chk("R1 clean superframe", bad != 0, 1'b0);
      send(3, 1'b1);
      chk("R1 errored Ft frame 3", o_fe, 1'b1);
      send(9, 1'b0);
      chk("R1 errored Ft frame 9", o_fe, 1'b1);
      send(10, 1'b0);
      chk("R2 Fs excluded by default", o_fe, 1'b0);
   endtask

   task automatic t_fs();
      restart(2'b11);
      fs_incl = 1;
      send(6, 1'b0);
      chk("R2 errored Fs frame 6 included", o_fe, 1'b1);
      send(4, 1'b0);
      chk("R2 correct Fs frame 4", o_fe, 1'b0);
      sec_yel_en = 1;
      send(12, 1'b1);
      chk("R3 frame 12 excluded with sec yellow", o_fe, 1'b0);
      send(2, 1'b1);
      chk("R3 other Fs still included", o_fe, 1'b1);
      sec_yel_en = 0;
      send(12, 1'b1);
      chk("R3 frame 12 included", o_fe, 1'b1);
   endtask

   task automatic t_esf();
      restart(2'b11);
      esf_mode = 1; fs_incl = 0;
      send(4, 1'b1);
      chk("R4 errored frame 4", o_fe, 1'b1);
      send(12, 1'b0);
      chk("R4 errored frame 12", o_fe, 1'b1);
      send(24, 1'b1);
      chk("R4 correct frame 24", o_fe, 1'b0);
      send(16, 1'b0);
      chk("R4 correct frame 16", o_fe, 1'b0);
      send(5, 1'b1);
      chk("R4 frame 5 ignored", o_fe, 1'b0);
      send(6, 1'b0);
      chk("R4 frame 6 ignored", o_fe, 1'b0);
   endtask

   task automatic t_window(input logic [1:0] crit, input int gap, input logic exp_rf,
                           input string tag);
      int f = 1;
      int early = 0;
      restart(crit);
      send(f, !d4_exp(f));
      if (o_rf) early++;
      for (int k = 1; k < gap; k++) begin
         f = (f >= 11) ? 1 : f + 2;
         send(f, d4_exp(f));
         if (o_rf) early++;
      end
      f = (f >= 11) ? 1 : f + 2;
      send(f, !d4_exp(f));
      chk({tag, " no early request"}, early != 0, 1'b0);
      chk({tag, " second error"}, o_rf, exp_rf);
   endtask

   task automatic t_crit_off();
      int fe = 0, rf = 0;
      restart(2'b11);
      for (int k = 0; k < 6; k++) begin
         send(1, 1'b0);
         fe += int'(o_fe);
         rf += int'(o_rf);
      end
      chk("R7 errors still counted", fe == 6, 1'b1);
      chk("R7 no reframe", rf != 0, 1'b0);
   endtask

   task automatic t_manual();
      restart(2'b11);
      man_reframe = 1;
      tick();
      chk("R8 manual rise", reframe_req, 1'b1);
      tick();
      chk("R9 single cycle manual", reframe_req, 1'b0);
      tick();
      chk("R8 held gives none", reframe_req, 1'b0);
      man_reframe = 0;
      tick();
      man_reframe = 1;
      tick();
      chk("R8 second rise", reframe_req, 1'b1);
      rst_n = 0;
      tick();
      rst_n = 1;
      tick();
      chk("R8 level through reset ignored", reframe_req, 1'b0);
      man_reframe = 0;
   endtask

   task automatic t_after();
      restart(2'b00);
      send(3, 1'b1);
      send(5, 1'b0);
      chk("R5 consecutive errors", o_rf, 1'b1);
      tick();
      chk("R9 request one cycle", reframe_req, 1'b0);
      send(7, 1'b1);
      chk("R9 idle after reframe ferr", o_fe, 1'b0);
      send(9, 1'b0);
      chk("R9 idle after reframe rf", o_rf, 1'b0);
      in_sync = 0; tick(); tick();
      in_sync = 1; tick(); tick();
      send(11, 1'b1);
      chk("R9 resumed counting", o_fe, 1'b1);
      chk("R9 history cleared", o_rf, 1'b0);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_d4_ft();
      t_fs();
      t_esf();
      t_window(2'b00, 3, 1'b1, "R5 win4 gap3");
      t_window(2'b00, 4, 1'b0, "R5 win4 gap4");
      t_window(2'b01, 4, 1'b1, "R6 win5 gap4");
      t_window(2'b01, 5, 1'b0, "R6 win5 gap5");
      t_window(2'b10, 5, 1'b1, "R6 win6 gap5");
      t_window(2'b10, 6, 1'b0, "R6 win6 gap6");
      t_crit_off();
      t_manual();
      t_after();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PER * 100000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule